// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recently used page translations close to the address path of a 32-bit core with 4 KB pages. A lookup presents a linear address. The upper 20 bits, the virtual page number, are searched among the stored entries. On a hit, the block returns the physical address in the same cycle: the stored frame number with the untouched 12-bit page offset below it. It also returns the cached user, write and dirty attributes of that page. On a miss it raises a miss flag, and the surrounding logic walks the page tables.

When the walk finishes, the walker writes the new translation through the fill port, so later accesses to that page hit. A flush input empties the whole cache in one cycle, for example when the page directory base changes. Table walking, protection checks and fault reporting belong to other blocks.

The default organisation holds 32 entries as 8 sets of 4 ways. Replacement inside a set uses a tree pseudo-LRU.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, and every lookup misses until a fill has happened.
- R2: A lookup splits the linear address as follows: bits 14:12 pick the set and bits 31:15 are the tag. A lookup with lk_valid=1 that matches a valid entry gives lk_hit=1 and lk_miss=0 in the same cycle.
- R3: On a hit, lk_phys_addr equals {stored 20-bit frame, lk_lin_addr[11:0]}, and lk_user, lk_write and lk_dirty give the stored attributes. Without a hit, all of these outputs are 0.
- R4: A lookup with lk_valid=1 and no match gives lk_miss=1 and lk_hit=0. With lk_valid=0, both flags are 0.
- R5: A fill (fill_valid=1) stores fill_frame and the three attributes for page fill_vpn at the clock edge. A lookup of that page in the next cycle hits and returns them.
- R6: A fill of a page that is already present overwrites its existing way in place, so the page never occupies two ways.
- R7: A fill into a set that has an invalid way uses the lowest-numbered invalid way, whatever the replacement state says.
- R8: Each set keeps 3 replacement bits. Bit 0 picks a half: 0 means ways 0-1, 1 means ways 2-3. Bit 1 picks within the left half: 0 means way 0. Bit 2 picks within the right half: 0 means way 2. A hit or a fill on a way sets the bits on its path to point away from it. Reset and flush clear the bits. A fill into a full set evicts the way the bits point to.
- R9: flush=1 clears every valid bit at the clock edge. A lookup in the flush cycle misses, and a fill in the flush cycle is dropped.
- R10: When a lookup and a fill hit the same set in one cycle, the fill is performed and the lookup reports a miss. Lookups in other sets are unaffected.
- R11: All 32 distinct pages, four per set, can be resident at once and all hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_lin_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_miss | output | 1 | Lookup found no usable translation |
| lk_phys_addr | output | 32 | Translated physical address, 0 without a hit |
| lk_user | output | 1 | Cached user-access attribute |
| lk_write | output | 1 | Cached write-permission attribute |
| lk_dirty | output | 1 | Cached dirty attribute |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_frame | input | 20 | Physical frame number for that page |
| fill_user | input | 1 | User attribute to store |
| fill_write | input | 1 | Write attribute to store |
| fill_dirty | input | 1 | Dirty attribute to store |

## Verification
The bench fills a set so that the pseudo-LRU state points at way 0 while way 3 is still empty. A design that lets the replacement bits win over the free way evicts a live page, and that page then misses. A second page is refilled with a new frame, and the bench expects the new frame back. A design that allocates a second way for the refill returns the stale frame from the lower way. The bench drives an exact order of hits and fills into a full set and expects a specific page to be evicted, so a tree update that points toward the touched way, or fails to update on hits, evicts the wrong page. The bench also drives a same-set fill together with a lookup, and a lookup or a fill during flush. A design with the wrong priority in either case reports a hit or keeps a dropped entry.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
   // Attribute bits cached alongside each translation.
   typedef struct packed {
      logic user;
      logic wr;
      logic dirty;
   } pte_attr_t;
endpackage

// File: rtl/tlbc_set_match.sv
// Compares one key against every way of a set; reports the lowest matching way.
module tlbc_set_match #(
   parameter int NUM_WAYS = 4,
   parameter int TAG_W    = 17
) (
   input  logic [NUM_WAYS-1:0]       way_vld,
   input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
   input  logic [TAG_W-1:0]          key,
   output logic                      any,
   output logic [$clog2(NUM_WAYS)-1:0] idx
);
   localparam int WAY_W = $clog2(NUM_WAYS);

   logic [NUM_WAYS-1:0] eq;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign eq[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == key);
   end

   assign any = |eq;

   always_comb begin
      idx = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (eq[w]) idx = WAY_W'(w);
      end
   end
endmodule

// File: rtl/tlbc_plru_victim.sv
// Walks the pseudo-LRU tree from the root to the way it points at.
module tlbc_plru_victim #(
   parameter int NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-2:0]         state,
   output logic [$clog2(NUM_WAYS)-1:0] victim
);
   localparam int WAY_W = $clog2(NUM_WAYS);

   always_comb begin
      int node;
      node   = 0;
      victim = '0;
      for (int l = 0; l < WAY_W; l++) begin
         victim[WAY_W-1-l] = state[node];
         node = 2 * node + 1 + (state[node] ? 1 : 0);
      end
   end
endmodule

// File: rtl/tlbc_plru_touch.sv
// Returns the tree state after an access to one way: every node on its path points away.
module tlbc_plru_touch #(
   parameter int NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-2:0]         state,
   input  logic [$clog2(NUM_WAYS)-1:0] way,
   output logic [NUM_WAYS-2:0]         nxt
);
   localparam int WAY_W = $clog2(NUM_WAYS);

   always_comb begin
      int node;
      node = 0;
      nxt  = state;
      for (int l = 0; l < WAY_W; l++) begin
         nxt[node] = ~way[WAY_W-1-l];
         node = 2 * node + 1 + (way[WAY_W-1-l] ? 1 : 0);
      end
   end
endmodule

// File: rtl/tlbc_fill_pick.sv
// Chooses the destination way of a fill: existing copy, then lowest free way, then tree victim.
module tlbc_fill_pick #(
   parameter int NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-1:0]         way_vld,
   input  logic                        present,
   input  logic [$clog2(NUM_WAYS)-1:0] present_idx,
   input  logic [$clog2(NUM_WAYS)-1:0] lru_idx,
   output logic [$clog2(NUM_WAYS)-1:0] pick
);
   localparam int WAY_W = $clog2(NUM_WAYS);

   logic                free_any;
   logic [WAY_W-1:0]    free_idx;

   always_comb begin
      free_idx = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (!way_vld[w]) free_idx = WAY_W'(w);
      end
   end

   assign free_any = ~&way_vld;

   always_comb begin
      if (present)       pick = present_idx;
      else if (free_any) pick = free_idx;
      else               pick = lru_idx;
   end
endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
   import tlbc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PADDR_W   = 32,
   parameter int PAGE_BITS = 12,
   parameter int NUM_SETS  = 8,
   parameter int NUM_WAYS  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          lk_valid,
   input  logic [ADDR_W-1:0]             lk_lin_addr,
   output logic                          lk_hit,
   output logic                          lk_miss,
   output logic [PADDR_W-1:0]            lk_phys_addr,
   output logic                          lk_user,
   output logic                          lk_write,
   output logic                          lk_dirty,
   input  logic                          fill_valid,
   input  logic [ADDR_W-PAGE_BITS-1:0]   fill_vpn,
   input  logic [PADDR_W-PAGE_BITS-1:0]  fill_frame,
   input  logic                          fill_user,
   input  logic                          fill_write,
   input  logic                          fill_dirty
);
   localparam int SET_W   = $clog2(NUM_SETS);
   localparam int WAY_W   = $clog2(NUM_WAYS);
   localparam int VPN_W   = ADDR_W - PAGE_BITS;
   localparam int TAG_W   = VPN_W - SET_W;
   localparam int FRAME_W = PADDR_W - PAGE_BITS;
   localparam int TREE_W  = NUM_WAYS - 1;

   // ---------------- elaboration-time parameter checks ----------------
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two, at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits above page offset and set index");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("PADDR_W must exceed PAGE_BITS");
   end

   // ---------------- storage ----------------
   logic [NUM_WAYS-1:0] vld_q  [NUM_SETS];
   logic [TREE_W-1:0]   plru_q [NUM_SETS];
   logic [TAG_W-1:0]    tag_q  [NUM_SETS][NUM_WAYS];
   logic [FRAME_W-1:0]  frm_q  [NUM_SETS][NUM_WAYS];
   pte_attr_t           attr_q [NUM_SETS][NUM_WAYS];

   // ---------------- lookup side ----------------
   logic [SET_W-1:0]          lk_set;
   logic [TAG_W-1:0]          lk_tag;
   logic [NUM_WAYS*TAG_W-1:0] lk_tags_flat;
   logic                      lk_any;
   logic [WAY_W-1:0]          lk_idx;
   logic                      same_set_fill;
   logic [TREE_W-1:0]         lk_plru_nxt;

   assign lk_set = lk_lin_addr[PAGE_BITS +: SET_W];
   assign lk_tag = lk_lin_addr[ADDR_W-1 -: TAG_W];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_lk_tags
      assign lk_tags_flat[w*TAG_W +: TAG_W] = tag_q[lk_set][w];
   end

   tlbc_set_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lk_match (
      .way_vld  (vld_q[lk_set]),
      .way_tags (lk_tags_flat),
      .key      (lk_tag),
      .any      (lk_any),
      .idx      (lk_idx)
   );

   // ---------------- fill side ----------------
   logic [SET_W-1:0]          fl_set;
   logic [TAG_W-1:0]          fl_tag;
   logic [NUM_WAYS*TAG_W-1:0] fl_tags_flat;
   logic                      fl_any;
   logic [WAY_W-1:0]          fl_idx;
   logic [WAY_W-1:0]          fl_lru;
   logic [WAY_W-1:0]          fl_way;
   logic [TREE_W-1:0]         fl_plru_nxt;
   logic                      fill_go;

   assign fl_set  = fill_vpn[SET_W-1:0];
   assign fl_tag  = fill_vpn[VPN_W-1 -: TAG_W];
   assign fill_go = fill_valid && !flush;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_fl_tags
      assign fl_tags_flat[w*TAG_W +: TAG_W] = tag_q[fl_set][w];
   end

   tlbc_set_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_fl_match (
      .way_vld  (vld_q[fl_set]),
      .way_tags (fl_tags_flat),
      .key      (fl_tag),
      .any      (fl_any),
      .idx      (fl_idx)
   );

   tlbc_plru_victim #(.NUM_WAYS(NUM_WAYS)) u_fl_victim (
      .state  (plru_q[fl_set]),
      .victim (fl_lru)
   );

   tlbc_fill_pick #(.NUM_WAYS(NUM_WAYS)) u_fl_pick (
      .way_vld     (vld_q[fl_set]),
      .present     (fl_any),
      .present_idx (fl_idx),
      .lru_idx     (fl_lru),
      .pick        (fl_way)
   );

   tlbc_plru_touch #(.NUM_WAYS(NUM_WAYS)) u_fl_touch (
      .state (plru_q[fl_set]),
      .way   (fl_way),
      .nxt   (fl_plru_nxt)
   );

   tlbc_plru_touch #(.NUM_WAYS(NUM_WAYS)) u_lk_touch (
      .state (plru_q[lk_set]),
      .way   (lk_idx),
      .nxt   (lk_plru_nxt)
   );

   // ---------------- lookup result ----------------
   assign same_set_fill = fill_valid && (fl_set == lk_set);
   assign lk_hit  = lk_valid && lk_any && !flush && !same_set_fill;
   assign lk_miss = lk_valid && !lk_hit;

   pte_attr_t lk_attr;
   assign lk_attr = attr_q[lk_set][lk_idx];

   always_comb begin
      if (lk_hit) begin
         lk_phys_addr = {frm_q[lk_set][lk_idx], lk_lin_addr[PAGE_BITS-1:0]};
         lk_user      = lk_attr.user;
         lk_write     = lk_attr.wr;
         lk_dirty     = lk_attr.dirty;
      end else begin
         lk_phys_addr = '0;
         lk_user      = 1'b0;
         lk_write     = 1'b0;
         lk_dirty     = 1'b0;
      end
   end

   // ---------------- state update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            vld_q[s]  <= '0;
            plru_q[s] <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            vld_q[s]  <= '0;
            plru_q[s] <= '0;
         end
      end else begin
         if (fill_valid) begin
            vld_q[fl_set][fl_way] <= 1'b1;
            plru_q[fl_set]        <= fl_plru_nxt;
         end
         if (lk_hit) begin
            plru_q[lk_set] <= lk_plru_nxt;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         tag_q[fl_set][fl_way]  <= fl_tag;
         frm_q[fl_set][fl_way]  <= fill_frame;
         attr_q[fl_set][fl_way] <= '{user: fill_user, wr: fill_write, dirty: fill_dirty};
      end
   end
endmodule

// File: rtl/tlbc_checker.sv
module tlbc_checker #(
   parameter int ADDR_W    = 32,
   parameter int PADDR_W   = 32,
   parameter int PAGE_BITS = 12,
   parameter int NUM_SETS  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         flush,
   input logic                         lk_valid,
   input logic [ADDR_W-1:0]            lk_lin_addr,
   input logic                         lk_hit,
   input logic                         lk_miss,
   input logic [PADDR_W-1:0]           lk_phys_addr,
   input logic                         lk_user,
   input logic                         lk_write,
   input logic                         lk_dirty,
   input logic                         fill_valid,
   input logic [ADDR_W-PAGE_BITS-1:0]  fill_vpn,
   input logic [PADDR_W-PAGE_BITS-1:0] fill_frame,
   input logic                         fill_user,
   input logic                         fill_write,
   input logic                         fill_dirty
);
   localparam int SET_W = $clog2(NUM_SETS);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic same_set;
   assign same_set = lk_lin_addr[PAGE_BITS +: SET_W] == fill_vpn[SET_W-1:0];

   // R1: nothing can hit in the first cycle out of reset
   p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !past_ok |-> !lk_hit);

   // R4: a valid lookup gives exactly one of hit and miss
   p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit ^ lk_miss));

   // R4: no lookup, no flags
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss));

   // R3: the page offset passes through on a hit
   p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_phys_addr[PAGE_BITS-1:0] == lk_lin_addr[PAGE_BITS-1:0]);

   // R3: outputs are zero without a hit
   p_quiet_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_phys_addr == '0 && !lk_user && !lk_write && !lk_dirty));

   // R9: no hit in the flush cycle, nor in the cycle after
   p_flush_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !lk_hit);
   p_flush_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

   // R10: same-set fill forces the lookup to miss
   p_fill_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && fill_valid && same_set) |-> lk_miss);

   // R5: a fill is visible to a lookup of the same page one cycle later
   p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(fill_valid && !flush) && lk_valid && !flush
       && !(fill_valid && same_set)
       && lk_lin_addr[ADDR_W-1:PAGE_BITS] == $past(fill_vpn))
      |-> (lk_hit && lk_phys_addr[PADDR_W-1:PAGE_BITS] == $past(fill_frame)
           && lk_user == $past(fill_user) && lk_write == $past(fill_write)
           && lk_dirty == $past(fill_dirty)));
endmodule

bind page_xlate_cache tlbc_checker #(
   .ADDR_W    (ADDR_W),
   .PADDR_W   (PADDR_W),
   .PAGE_BITS (PAGE_BITS),
   .NUM_SETS  (NUM_SETS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .lk_valid     (lk_valid),
   .lk_lin_addr  (lk_lin_addr),
   .lk_hit       (lk_hit),
   .lk_miss      (lk_miss),
   .lk_phys_addr (lk_phys_addr),
   .lk_user      (lk_user),
   .lk_write     (lk_write),
   .lk_dirty     (lk_dirty),
   .fill_valid   (fill_valid),
   .fill_vpn     (fill_vpn),
   .fill_frame   (fill_frame),
   .fill_user    (fill_user),
   .fill_write   (fill_write),
   .fill_dirty   (fill_dirty)
);

// File: tb/page_xlate_cache_tb.sv
module page_xlate_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_lin_addr = '0;
   logic        lk_hit, lk_miss;
   logic [31:0] lk_phys_addr;
   logic        lk_user, lk_write, lk_dirty;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_frame = '0;
   logic        fill_user = 1'b0, fill_write = 1'b0, fill_dirty = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   page_xlate_cache u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_lin_addr(lk_lin_addr),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_phys_addr(lk_phys_addr),
      .lk_user(lk_user), .lk_write(lk_write), .lk_dirty(lk_dirty),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
      .fill_user(fill_user), .fill_write(fill_write), .fill_dirty(fill_dirty)
   );

   function automatic logic [19:0] vpn_of(input int k, input int set);
      return 20'((k << 3) | set);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Lookup held across one clock edge; results sampled 1 ns after the falling edge.
   task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] off,
                       input bit exp_hit, input logic [19:0] exp_frame,
                       input logic [2:0] exp_attr);
      @(negedge clk);
      lk_valid    = 1'b1;
      lk_lin_addr = {vpn, off};
      #1;
      check(req, "hit",  32'(lk_hit),  32'(exp_hit));
      check(req, "miss", 32'(lk_miss), 32'(!exp_hit));
      check(req, "phys", lk_phys_addr, exp_hit ? {exp_frame, off} : 32'h0);
      check(req, "attr", 32'({lk_user, lk_write, lk_dirty}), exp_hit ? 32'(exp_attr) : 32'h0);
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] frame, input logic [2:0] attr);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_vpn   = vpn;
      fill_frame = frame;
      {fill_user, fill_write, fill_dirty} = attr;
      @(posedge clk);
      #1 fill_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R1", "hit in reset", 32'(lk_hit), 32'h0);
      look("R1", vpn_of(0, 0), 12'h000, 1'b0, '0, '0);
      look("R1", vpn_of(9, 3), 12'h123, 1'b0, '0, '0);
   endtask

   task automatic t_basic();
      look("R4", vpn_of(1, 1), 12'h010, 1'b0, '0, '0);
      fill(vpn_of(1, 1), 20'hABCDE, 3'b101);
      look("R5", vpn_of(1, 1), 12'h010, 1'b1, 20'hABCDE, 3'b101);
      look("R2", vpn_of(1, 1), 12'h777, 1'b1, 20'hABCDE, 3'b101);
      // same set, different tag: must miss
      look("R2", vpn_of(2, 1), 12'h010, 1'b0, '0, '0);
      // same tag, different set: must miss
      look("R2", vpn_of(1, 2), 12'h010, 1'b0, '0, '0);
      // no lookup: quiet outputs
      @(negedge clk);
      lk_lin_addr = {vpn_of(1, 1), 12'h010};
      #1;
      check("R4", "hit idle",  32'(lk_hit),  32'h0);
      check("R4", "miss idle", 32'(lk_miss), 32'h0);
      check("R3", "phys idle", lk_phys_addr, 32'h0);
   endtask

   task automatic t_offsets();
      fill(vpn_of(3, 1), 20'h00F0F, 3'b010);
      look("R3", vpn_of(3, 1), 12'h000, 1'b1, 20'h00F0F, 3'b010);
      look("R3", vpn_of(3, 1), 12'hFFF, 1'b1, 20'h00F0F, 3'b010);
      look("R3", vpn_of(3, 1), 12'hA5A, 1'b1, 20'h00F0F, 3'b010);
   endtask

   task automatic t_refresh();
      fill(vpn_of(1, 6), 20'h00111, 3'b000);
      fill(vpn_of(1, 6), 20'h00222, 3'b111);
      look("R6", vpn_of(1, 6), 12'h004, 1'b1, 20'h00222, 3'b111);
      fill(vpn_of(2, 6), 20'h00333, 3'b001);
      fill(vpn_of(3, 6), 20'h00444, 3'b001);
      fill(vpn_of(4, 6), 20'h00555, 3'b001);
      look("R6", vpn_of(1, 6), 12'h008, 1'b1, 20'h00222, 3'b111);
      look("R6", vpn_of(2, 6), 12'h008, 1'b1, 20'h00333, 3'b001);
      look("R6", vpn_of(3, 6), 12'h008, 1'b1, 20'h00444, 3'b001);
      look("R6", vpn_of(4, 6), 12'h008, 1'b1, 20'h00555, 3'b001);
   endtask

   // Three fills leave the tree pointing at way 0 while way 3 is free.
   task automatic t_free_first();
      fill(vpn_of(1, 2), 20'h01001, 3'b100);
      fill(vpn_of(2, 2), 20'h01002, 3'b100);
      fill(vpn_of(3, 2), 20'h01003, 3'b100);
      fill(vpn_of(4, 2), 20'h01004, 3'b100);
      look("R7", vpn_of(1, 2), 12'h0, 1'b1, 20'h01001, 3'b100);
      look("R7", vpn_of(2, 2), 12'h0, 1'b1, 20'h01002, 3'b100);
      look("R7", vpn_of(3, 2), 12'h0, 1'b1, 20'h01003, 3'b100);
      look("R7", vpn_of(4, 2), 12'h0, 1'b1, 20'h01004, 3'b100);
   endtask

   // Set 5: A,B,C,D in ways 0..3, hit A, fill E -> evicts C (way 2).
   // Then hits A,B,D,E leave the tree pointing at way 0 -> fill F evicts A.
   task automatic t_replace();
      fill(vpn_of(1, 5), 20'h05001, 3'b000);
      fill(vpn_of(2, 5), 20'h05002, 3'b000);
      fill(vpn_of(3, 5), 20'h05003, 3'b000);
      fill(vpn_of(4, 5), 20'h05004, 3'b000);
      look("R8", vpn_of(1, 5), 12'h0, 1'b1, 20'h05001, 3'b000);
      fill(vpn_of(5, 5), 20'h05005, 3'b000);
      look("R8", vpn_of(3, 5), 12'h0, 1'b0, '0, '0);
      look("R8", vpn_of(1, 5), 12'h0, 1'b1, 20'h05001, 3'b000);
      look("R8", vpn_of(2, 5), 12'h0, 1'b1, 20'h05002, 3'b000);
      look("R8", vpn_of(4, 5), 12'h0, 1'b1, 20'h05004, 3'b000);
      look("R8", vpn_of(5, 5), 12'h0, 1'b1, 20'h05005, 3'b000);
      fill(vpn_of(6, 5), 20'h05006, 3'b000);
      look("R8", vpn_of(1, 5), 12'h0, 1'b0, '0, '0);
      look("R8", vpn_of(6, 5), 12'h0, 1'b1, 20'h05006, 3'b000);
      look("R8", vpn_of(2, 5), 12'h0, 1'b1, 20'h05002, 3'b000);
   endtask

   task automatic t_conflict();
      fill(vpn_of(1, 3), 20'h03001, 3'b011);
      fill(vpn_of(1, 4), 20'h04001, 3'b011);
      // lookup of a resident page in set 3 while set 3 is filled
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn_of(2, 3); fill_frame = 20'h03002;
      {fill_user, fill_write, fill_dirty} = 3'b110;
      lk_valid = 1'b1; lk_lin_addr = {vpn_of(1, 3), 12'h00C};
      #1;
      check("R10", "hit same set",  32'(lk_hit),  32'h0);
      check("R10", "miss same set", 32'(lk_miss), 32'h1);
      // other set during the same fill is served
      lk_lin_addr = {vpn_of(1, 4), 12'h00C};
      #1;
      check("R10", "hit other set", 32'(lk_hit), 32'h1);
      check("R10", "phys other set", lk_phys_addr, {20'h04001, 12'h00C});
      @(posedge clk);
      #1 begin fill_valid = 1'b0; lk_valid = 1'b0; end
      look("R10", vpn_of(2, 3), 12'h0, 1'b1, 20'h03002, 3'b110);
      look("R10", vpn_of(1, 3), 12'h0, 1'b1, 20'h03001, 3'b011);
   endtask

   task automatic t_flush();
      fill(vpn_of(1, 7), 20'h07001, 3'b001);
      @(negedge clk);
      flush = 1'b1;
      lk_valid = 1'b1; lk_lin_addr = {vpn_of(1, 7), 12'h0};
      fill_valid = 1'b1; fill_vpn = vpn_of(2, 0); fill_frame = 20'h00999;
      #1;
      check("R9", "hit during flush",  32'(lk_hit),  32'h0);
      check("R9", "miss during flush", 32'(lk_miss), 32'h1);
      @(posedge clk);
      #1 begin flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0; end
      look("R9", vpn_of(1, 7), 12'h0, 1'b0, '0, '0);
      look("R9", vpn_of(2, 0), 12'h0, 1'b0, '0, '0);
      look("R9", vpn_of(1, 1), 12'h0, 1'b0, '0, '0);
      look("R9", vpn_of(1, 5), 12'h0, 1'b0, '0, '0);
   endtask

   task automatic t_capacity();
      do_flush();
      for (int i = 0; i < 32; i++) fill(20'(i), 20'(32'h100 + i), 3'(i));
      for (int i = 0; i < 32; i++) look("R11", 20'(i), 12'(i * 5), 1'b1, 20'(32'h100 + i), 3'(i));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      #2 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_offsets();
      t_refresh();
      t_free_first();
      t_replace();
      t_conflict();
      t_flush();
      t_capacity();
      repeat (2) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule